// File: doc/BRIEF.md
# Multi-Master Shared-Bus Arbitration Unit

Each master on a shared system bus has its own copy of this unit. The master raises a level request when it needs the bus. It marks each bus transfer with a cycle-active level and can pin ownership with an active-low lock. The unit puts an active-low request onto the shared bus, where an external parallel resolver turns the requests of all masters into one active-low priority grant per master. The unit takes the bus when it holds priority and no other master is busy. It then drives the shared busy line low and enables the master's address latches and bus controller.

Ownership only ends between transfers, never while a transfer is in flight. The unit gives the bus up when it loses priority, when its master has gone idle while a lower-priority master waits, or, with the any-request option set, whenever a lower-priority master waits. A low lock input overrides all of these. The three shared-bus inputs cross clock domains through synchronizer stages. The local master-side inputs are synchronous to the unit's clock. There is no data path, so no valid/ready handshake applies. Every pin is a plain control level.

Top module: `bus_arb_top`

## Requirements
- R1: While `rst` is high and on the clock after it, the unit does not own the bus, and `breq_n_o`, `busy_n_o`, `cbrq_n_o` and `aen_n_o` are all 1.
- R2: When idle, a high `req_i` drives `breq_n_o` to 0 one clock later. `breq_n_o` stays 0 for as long as the unit requests or owns the bus.
- R3: A requesting unit takes the bus one clock after its synchronized view shows `bprn_n_i` = 0 and `busy_n_i` = 1. It then drives `busy_n_o` to 0. Each shared-bus input reaches that view after `SYNC_STAGES` (default 2) clocks.
- R4: While `busy_n_i` = 0 (another master's transfer is in progress), a requesting unit does not take the bus.
- R5: `aen_n_o` is 0 exactly in the cycles where `busy_n_o` is 0. Both return to 1 in the same cycle when ownership ends.
- R6: If the owner loses priority (`bprn_n_i` = 1), it keeps the bus while `cyc_i` = 1. It releases one clock after the synchronized loss is seen with `cyc_i` = 0.
- R7: While `lock_n_i` = 0, the owner keeps the bus even when priority is lost, the cycle is idle and lower-priority masters wait.
- R8: With `any_rq_i` = 0 and `req_i` = 1, the owner keeps the bus between transfers even when `cbrq_n_i` = 0.
- R9: With `any_rq_i` = 0, an owner whose `req_i` = 0 keeps the bus while `cbrq_n_i` = 1. It releases one clock after `cbrq_n_i` = 0 is seen with `cyc_i` = 0.
- R10: With `any_rq_i` = 1, the owner releases one clock after `cyc_i` falls to 0 while a synchronized `cbrq_n_i` = 0 is seen, even with `req_i` = 1.
- R11: If `req_i` drops before the bus is granted, `breq_n_o` and `cbrq_n_o` return to 1 one clock later.
- R12: `cbrq_n_o` is 0 only while the unit requests without owning. It is 1 while the unit owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Master needs the shared bus (level) |
| cyc_i | input | 1 | A master transfer is in progress (level) |
| lock_n_i | input | 1 | Active-low lock; holds ownership |
| any_rq_i | input | 1 | Any-request option: yield to waiting lower-priority masters |
| bprn_n_i | input | 1 | Active-low priority grant from the external resolver |
| busy_n_i | input | 1 | Sensed level of the shared busy line, low while any master owns |
| cbrq_n_i | input | 1 | Sensed level of the shared common-request line |
| breq_n_o | output | 1 | Active-low request to the external resolver |
| busy_n_o | output | 1 | Active-low busy drive onto the shared line |
| cbrq_n_o | output | 1 | Active-low common-request drive onto the shared line |
| aen_n_o | output | 1 | Active-low enable for the address latches and bus controller |

## Verification
On every cycle, the bound checker confirms that the local enable tracks the busy drive and that the request stays low whenever the bus is owned. It also confirms that the common request is never driven by the owner and that ownership holds through an active transfer or a lock. Every fall of the busy drive must follow a synchronized view of priority held and the bus free. Release timing is a different matter. The exact clock of release after a lost grant, the difference between parking on the bus and yielding it under the any-request option, and the synchronizer delay seen at the pins all depend on stimulus history. Only the bench's directed scenarios show these.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic breq_n;
    logic busy_n;
    logic cbrq_n;
    logic aen_n;
  } arb_drive_t;

  localparam arb_drive_t DRIVE_OFF = '{breq_n: 1'b1, busy_n: 1'b1, cbrq_n: 1'b1, aen_n: 1'b1};
endpackage

// File: rtl/bus_arb_sync.sv
module bus_arb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[LAST];
endmodule

// File: rtl/bus_arb_policy.sv
module bus_arb_policy (
  input  logic cyc_i,
  input  logic lock_n_i,
  input  logic req_i,
  input  logic any_rq_i,
  input  logic bprn_q,
  input  logic busy_q,
  input  logic cbrq_q,
  output logic grant_ok,
  output logic yield_now
);
  logic prio_lost;
  logic lower_wait;
  logic yield_lower;
  logic boundary;

  // Bus may be taken only with priority held and nobody busy.
  assign grant_ok    = !bprn_q && busy_q;

  assign prio_lost   = bprn_q;
  assign lower_wait  = !cbrq_q;
  // Idle masters always yield to waiters; any-request yields regardless.
  assign yield_lower = lower_wait && (any_rq_i || !req_i);
  // Release happens only between transfers and never under lock.
  assign boundary    = !cyc_i && lock_n_i;

  assign yield_now   = boundary && (prio_lost || yield_lower);
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       grant_ok,
  input  logic       yield_now,
  output arb_drive_t drive_o,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;
  arb_drive_t drive_q, drive_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (req_i) state_d = ARB_WAIT;
      ARB_WAIT: begin
        if (!req_i)        state_d = ARB_IDLE;
        else if (grant_ok) state_d = ARB_OWN;
      end
      ARB_OWN:  if (yield_now) state_d = ARB_IDLE;
      default:  state_d = ARB_IDLE;
    endcase
  end

  // Outputs come from flops aligned with the state register.
  always_comb begin
    drive_d = DRIVE_OFF;
    unique case (state_d)
      ARB_WAIT: begin
        drive_d.breq_n = 1'b0;
        drive_d.cbrq_n = 1'b0;
      end
      ARB_OWN: begin
        drive_d.breq_n = 1'b0;
        drive_d.busy_n = 1'b0;
        drive_d.aen_n  = 1'b0;
      end
      default: drive_d = DRIVE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      drive_q <= DRIVE_OFF;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
    end
  end

  assign drive_o = drive_q;
  assign state_o = state_q;
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic cyc_i,
  input  logic lock_n_i,
  input  logic any_rq_i,
  input  logic bprn_n_i,
  input  logic busy_n_i,
  input  logic cbrq_n_i,
  output logic breq_n_o,
  output logic busy_n_o,
  output logic cbrq_n_o,
  output logic aen_n_o
);
  localparam int NSH = 3;

  logic [NSH-1:0] sh_raw, sh_sync;
  logic bprn_q, busy_q, cbrq_q;
  logic grant_ok, yield_now;
  arb_drive_t drive;
  arb_state_e state;

  assign sh_raw = {cbrq_n_i, busy_n_i, bprn_n_i};

  bus_arb_sync #(.WIDTH(NSH), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .async_i(sh_raw), .sync_o(sh_sync)
  );

  assign bprn_q = sh_sync[0];
  assign busy_q = sh_sync[1];
  assign cbrq_q = sh_sync[2];

  bus_arb_policy u_policy (
    .cyc_i(cyc_i), .lock_n_i(lock_n_i), .req_i(req_i), .any_rq_i(any_rq_i),
    .bprn_q(bprn_q), .busy_q(busy_q), .cbrq_q(cbrq_q),
    .grant_ok(grant_ok), .yield_now(yield_now)
  );

  bus_arb_fsm u_fsm (
    .clk(clk), .rst(rst), .req_i(req_i), .grant_ok(grant_ok),
    .yield_now(yield_now), .drive_o(drive), .state_o(state)
  );

  assign breq_n_o = drive.breq_n;
  assign busy_n_o = drive.busy_n;
  assign cbrq_n_o = drive.cbrq_n;
  assign aen_n_o  = drive.aen_n;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic cyc_i,
  input logic lock_n_i,
  input logic bprn_q,
  input logic busy_q,
  input logic breq_n_o,
  input logic busy_n_o,
  input logic cbrq_n_o,
  input logic aen_n_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (breq_n_o && busy_n_o && cbrq_n_o && aen_n_o));

  // R2
  req_while_own_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_n_o |-> !breq_n_o);

  // R3
  take_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n_o) |-> $past(!bprn_q && busy_q));

  // R5
  enable_busy_chk: assert property (@(posedge clk) disable iff (rst)
    aen_n_o == busy_n_o);

  // R6
  cyc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_n_o && cyc_i) |=> !busy_n_o);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_n_o && !lock_n_i) |=> !busy_n_o);

  // R11
  withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_i && busy_n_o) |=> (breq_n_o && cbrq_n_o));

  // R12
  common_not_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !cbrq_n_o |-> busy_n_o);
endmodule

bind bus_arb_top bus_arb_chk u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .cyc_i(cyc_i), .lock_n_i(lock_n_i),
  .bprn_q(bprn_q), .busy_q(busy_q), .breq_n_o(breq_n_o), .busy_n_o(busy_n_o),
  .cbrq_n_o(cbrq_n_o), .aen_n_o(aen_n_o)
);

// File: tb/tb_bus_arb_top.sv
module tb_bus_arb_top;
  logic clk = 1'b0;
  logic rst, req_i, cyc_i, lock_n_i, any_rq_i, bprn_n_i, busy_n_i, cbrq_n_i;
  logic breq_n_o, busy_n_o, cbrq_n_o, aen_n_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_arb_top dut (
    .clk(clk), .rst(rst), .req_i(req_i), .cyc_i(cyc_i), .lock_n_i(lock_n_i),
    .any_rq_i(any_rq_i), .bprn_n_i(bprn_n_i), .busy_n_i(busy_n_i),
    .cbrq_n_i(cbrq_n_i), .breq_n_o(breq_n_o), .busy_n_o(busy_n_o),
    .cbrq_n_o(cbrq_n_o), .aen_n_o(aen_n_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance n rising edges; return after the following falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_i = 1'b0; cyc_i = 1'b0; lock_n_i = 1'b1; any_rq_i = 1'b0;
    bprn_n_i = 1'b1; busy_n_i = 1'b1; cbrq_n_i = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  // Priority held, bus free; reach ownership with settled synchronizers.
  task automatic acquire();
    bprn_n_i = 1'b0; busy_n_i = 1'b1;
    req_i = 1'b1;
    step(4);
    chk("R3 owned after acquire", busy_n_o, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 breq after reset", breq_n_o, 1'b1);
    chk("R1 busy after reset", busy_n_o, 1'b1);
    chk("R1 cbrq after reset", cbrq_n_o, 1'b1);
    chk("R1 aen after reset",  aen_n_o,  1'b1);
  endtask

  task automatic t_acquire_timing();
    do_reset();
    bprn_n_i = 1'b0; busy_n_i = 1'b1;
    step(3);                 // synchronizers settled
    req_i = 1'b1;
    step(1);
    chk("R2 breq low one clock after req", breq_n_o, 1'b0);
    chk("R12 cbrq low while waiting", cbrq_n_o, 1'b0);
    chk("R3 not yet owning", busy_n_o, 1'b1);
    step(1);
    chk("R3 busy low on next clock", busy_n_o, 1'b0);
    chk("R5 aen low with busy", aen_n_o, 1'b0);
    chk("R12 cbrq high when owning", cbrq_n_o, 1'b1);
    chk("R2 breq still low when owning", breq_n_o, 1'b0);
  endtask

  task automatic t_busy_wait();
    do_reset();
    bprn_n_i = 1'b0; busy_n_i = 1'b0;
    req_i = 1'b1;
    step(6);
    chk("R4 no take while bus busy", busy_n_o, 1'b1);
    chk("R4 still requesting", breq_n_o, 1'b0);
    busy_n_i = 1'b1;
    step(2);
    chk("R4 sync delay not elapsed", busy_n_o, 1'b1);
    step(1);
    chk("R3 take after synced free", busy_n_o, 1'b0);
  endtask

  task automatic t_withdraw();
    do_reset();
    bprn_n_i = 1'b1;
    req_i = 1'b1;
    step(3);
    chk("R11 breq low before withdraw", breq_n_o, 1'b0);
    req_i = 1'b0;
    step(1);
    chk("R11 breq high after withdraw", breq_n_o, 1'b1);
    chk("R11 cbrq high after withdraw", cbrq_n_o, 1'b1);
  endtask

  task automatic t_prio_loss();
    do_reset();
    acquire();
    cyc_i = 1'b1;
    bprn_n_i = 1'b1;
    step(5);
    chk("R6 held during transfer", busy_n_o, 1'b0);
    cyc_i = 1'b0;
    step(1);
    chk("R6 busy released after transfer", busy_n_o, 1'b1);
    chk("R5 aen released with busy", aen_n_o, 1'b1);
    do_reset();
    acquire();
    bprn_n_i = 1'b1;
    step(2);
    chk("R6 owned until loss synced", busy_n_o, 1'b0);
    step(1);
    chk("R6 released one clock after synced loss", busy_n_o, 1'b1);
  endtask

  task automatic t_lock();
    do_reset();
    acquire();
    lock_n_i = 1'b0;
    bprn_n_i = 1'b1; cbrq_n_i = 1'b0; req_i = 1'b0;
    step(6);
    chk("R7 lock keeps bus", busy_n_o, 1'b0);
    lock_n_i = 1'b1;
    step(1);
    chk("R7 release after unlock", busy_n_o, 1'b1);
  endtask

  task automatic t_park();
    do_reset();
    acquire();
    cbrq_n_i = 1'b0;
    step(6);
    chk("R8 keeps bus with req high", busy_n_o, 1'b0);
    cbrq_n_i = 1'b1;
    step(3);
    req_i = 1'b0;
    step(4);
    chk("R9 idle owner parks without waiters", busy_n_o, 1'b1 ^ 1'b1);
    cbrq_n_i = 1'b0;
    step(2);
    chk("R9 not released before sync", busy_n_o, 1'b0);
    step(1);
    chk("R9 idle owner yields to waiter", busy_n_o, 1'b1);
  endtask

  task automatic t_any_rq();
    do_reset();
    any_rq_i = 1'b1;
    acquire();
    cyc_i = 1'b1;
    cbrq_n_i = 1'b0;
    step(5);
    chk("R10 held during transfer", busy_n_o, 1'b0);
    cyc_i = 1'b0;
    step(1);
    chk("R10 yields at transfer end", busy_n_o, 1'b1);
    chk("R5 aen off at yield", aen_n_o, 1'b1);
  endtask

  initial begin
    rst = 1'b1; req_i = 1'b0; cyc_i = 1'b0; lock_n_i = 1'b1; any_rq_i = 1'b0;
    bprn_n_i = 1'b1; busy_n_i = 1'b1; cbrq_n_i = 1'b1;
    t_reset();
    t_acquire_timing();
    t_busy_wait();
    t_withdraw();
    t_prio_loss();
    t_lock();
    t_park();
    t_any_rq();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule